// File: doc/BRIEF.md
# Pixel Colour Component Extractor

This block sits at the end of a display scan-out path. Each cycle it may receive one framebuffer pixel word of one to four bytes, and it turns that word into separate 8-bit red, green and blue values. Software programs one select word per colour channel. The select word says which bit the channel's field starts at, how many bits the field has, and which value the channel shows when no pixel data applies.

A bytes-per-pixel setting masks off the bytes of the word that lie above the configured pixel size. Two flags from the timing and fetch logic can override the pixel data. An active-area flag that is low marks blanking, and an underrun flag marks a pixel that the fetch logic failed to supply. While either override applies, every channel shows its own fallback value. A red fallback of 0xFF, for example, makes underruns show up as red on screen.

A field narrower than 8 bits is widened by repeating its bits from the top down, so full scale stays full scale. A field wider than 8 bits keeps only its top 8 bits. The result is registered, and a valid strobe follows the input strobe one cycle later.

Top module: `pix_unpack`

## Requirements
- R1: Bits [4:0] of a channel select word give the index, within the masked pixel word, of the lowest bit of that channel's field.
- R2: Bits [11:8] of a select word give the field length. A length from 1 to 7 is left-aligned into 8 bits, and the field bits, taken from the top down, are repeated until the low bits are filled.
- R3: A field length of 8 to 15 yields the top 8 bits of the field.
- R4: Bits [23:16] of a select word hold the channel's fallback value. A length of zero makes that channel output its fallback value.
- R5: When `in_active` is low, all three channels output their fallback values.
- R6: When `in_underrun` is high, all three channels output their fallback values. This holds even inside the active area.
- R7: Bits [4:3] of `pix_fmt` hold the bytes-per-pixel count minus one, so 0 means one byte and 3 means four bytes. Bytes of `in_word` at or above the configured byte count read as zero.
- R8: Field bits that would lie above bit 31 of the pixel word read as zero.
- R9: `out_valid` equals `in_valid` delayed by one clock. The colour outputs in the cycle after a valid input reflect that input.
- R10: While `in_valid` is low, the colour outputs keep their last values. Synchronous reset clears `out_valid` and all colour outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_fmt | input | 8 | Format setting; bits [4:3] hold bytes per pixel minus one |
| red_sel | input | 32 | Red select word: start bit, length, fallback |
| grn_sel | input | 32 | Green select word |
| blu_sel | input | 32 | Blue select word |
| in_valid | input | 1 | Pixel word present this cycle |
| in_word | input | 32 | Pixel word from the framebuffer |
| in_active | input | 1 | Pixel lies inside the visible area |
| in_underrun | input | 1 | Pixel source failed to deliver this pixel |
| out_valid | output | 1 | Registered colour triple is valid |
| out_r | output | 8 | Red output |
| out_g | output | 8 | Green output |
| out_b | output | 8 | Blue output |

## Verification
The bench targets fields of 1, 5, 6, 8 and 12 bits. A design with wrong widening would output 0xF8 instead of 0xFF for a full-scale 5-bit field, or would take the low bits of a 12-bit field instead of the top bits. The bench places fields in bytes above the configured pixel size and across bit 31, where a design that skipped masking would leak stale high bytes into the colour. It also covers zero lengths, blanking and underrun, including underrun inside the active area, where a design that ignored one flag would pass pixel data through in place of the fallback. Idle cycles with a changing input word expose outputs that do not hold their values.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

  // Channel select word layout
  localparam int SEL_W    = 32;
  localparam int OFF_LSB  = 0;
  localparam int OFF_W    = 5;
  localparam int LEN_LSB  = 8;
  localparam int LEN_W    = 4;
  localparam int DFLT_LSB = 16;
  localparam int DFLT_W   = 8;

  // Format setting layout
  localparam int FMT_W    = 8;
  localparam int BPP_LSB  = 3;
  localparam int BPP_W    = 2;

  typedef struct packed {
    logic [DFLT_W-1:0] dflt;
    logic [LEN_W-1:0]  len;
    logic [OFF_W-1:0]  off;
  } chan_sel_t;

  function automatic chan_sel_t decode_sel(input logic [SEL_W-1:0] w);
    chan_sel_t s;
    s.off  = w[OFF_LSB  +: OFF_W];
    s.len  = w[LEN_LSB  +: LEN_W];
    s.dflt = w[DFLT_LSB +: DFLT_W];
    return s;
  endfunction

endpackage

// File: rtl/pix_unpack_bytemask.sv
module pix_unpack_bytemask #(
  parameter int WORD_W = 32,
  localparam int NBYTES = WORD_W / 8,
  localparam int BIDX_W = $clog2(NBYTES)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [BIDX_W-1:0] bpp_m1,
  output logic [WORD_W-1:0] masked
);

  // Keep byte b only when b is below the configured byte count
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign masked[b*8 +: 8] = (BIDX_W'(b) <= bpp_m1) ? word[b*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/pix_unpack_chan.sv
module pix_unpack_chan
  import pix_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CH_W   = 8
) (
  input  logic [WORD_W-1:0] word,
  input  chan_sel_t         sel,
  input  logic              force_dflt,
  output logic [CH_W-1:0]   val
);

  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] field;
  logic [CH_W-1:0]   long_v;
  logic [CH_W-1:0]   rep_v;
  logic [OFF_W-1:0]  j;

  // Bits shifted in from above the word are zero
  assign shifted = word >> sel.off;
  assign field   = shifted & ~({WORD_W{1'b1}} << sel.len);
  assign long_v  = CH_W'(field >> (sel.len - LEN_W'(CH_W)));

  // Short fields: walk the field top-down and wrap to fill the channel
  always_comb begin
    rep_v = '0;
    j = OFF_W'(sel.len) - OFF_W'(1);
    for (int i = CH_W - 1; i >= 0; i--) begin
      rep_v[i] = field[j];
      if (j == '0) j = OFF_W'(sel.len) - OFF_W'(1);
      else         j = j - OFF_W'(1);
    end
  end

  always_comb begin
    if (force_dflt || sel.len == '0)      val = sel.dflt;
    else if (sel.len >= LEN_W'(CH_W))     val = long_v;
    else                                  val = rep_v;
  end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CH_W   = 8,
  parameter int NCH    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FMT_W-1:0]  pix_fmt,
  input  logic [SEL_W-1:0]  red_sel,
  input  logic [SEL_W-1:0]  grn_sel,
  input  logic [SEL_W-1:0]  blu_sel,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_active,
  input  logic              in_underrun,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_r,
  output logic [CH_W-1:0]   out_g,
  output logic [CH_W-1:0]   out_b
);

  localparam int NBYTES = WORD_W / 8;
  localparam int BIDX_W = $clog2(NBYTES);

  logic [WORD_W-1:0]           masked;
  logic [NCH-1:0][SEL_W-1:0]   sel_w;
  logic [NCH-1:0][CH_W-1:0]    ch_val;
  logic                        force_dflt;
  logic                        unused_fmt_bits;

  assign unused_fmt_bits = ^{pix_fmt[FMT_W-1:BPP_LSB+BPP_W], pix_fmt[BPP_LSB-1:0]};
  assign sel_w      = {red_sel, grn_sel, blu_sel};
  assign force_dflt = !in_active || in_underrun;

  pix_unpack_bytemask #(.WORD_W(WORD_W)) u_mask (
    .word   (in_word),
    .bpp_m1 (BIDX_W'(pix_fmt[BPP_LSB +: BPP_W])),
    .masked (masked)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic unused_sel_bits;
    assign unused_sel_bits = ^{sel_w[c][SEL_W-1:DFLT_LSB+DFLT_W],
                               sel_w[c][DFLT_LSB-1:LEN_LSB+LEN_W],
                               sel_w[c][LEN_LSB-1:OFF_LSB+OFF_W]};
    pix_unpack_chan #(.WORD_W(WORD_W), .CH_W(CH_W)) u_chan (
      .word       (masked),
      .sel        (decode_sel(sel_w[c])),
      .force_dflt (force_dflt),
      .val        (ch_val[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_r <= ch_val[2];
        out_g <= ch_val[1];
        out_b <= ch_val[0];
      end
    end
  end

endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  pix_fmt,
  input logic [31:0] red_sel,
  input logic [31:0] grn_sel,
  input logic [31:0] blu_sel,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        in_active,
  input logic        in_underrun,
  input logic        out_valid,
  input logic [7:0]  out_r,
  input logic [7:0]  out_g,
  input logic [7:0]  out_b
);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  idle_novalid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable({out_r, out_g, out_b}));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_r == 8'h00 && out_g == 8'h00 && out_b == 8'h00));

  // R6
  underrun_dflt_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_underrun) |=>
      (out_r == $past(red_sel[23:16]) && out_g == $past(grn_sel[23:16])
       && out_b == $past(blu_sel[23:16])));

  // R5
  blank_dflt_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_active) |=>
      (out_r == $past(red_sel[23:16]) && out_g == $past(grn_sel[23:16])
       && out_b == $past(blu_sel[23:16])));

  // R4
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && red_sel[11:8] == 4'h0) |=> (out_r == $past(red_sel[23:16])));

endmodule

bind pix_unpack pix_unpack_chk chk_i (.*);

// File: tb/pix_unpack_tb_top.sv
module pix_unpack_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  pix_fmt;
  logic [31:0] red_sel, grn_sel, blu_sel;
  logic        in_valid;
  logic [31:0] in_word;
  logic        in_active, in_underrun;
  logic        out_valid;
  logic [7:0]  out_r, out_g, out_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  pix_unpack dut_i (
    .clk(clk), .rst(rst), .pix_fmt(pix_fmt),
    .red_sel(red_sel), .grn_sel(grn_sel), .blu_sel(blu_sel),
    .in_valid(in_valid), .in_word(in_word),
    .in_active(in_active), .in_underrun(in_underrun),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  function automatic logic [31:0] mk_sel(input int off, input int len, input logic [7:0] dflt);
    return {8'h00, dflt, 4'h0, 4'(len), 3'b000, 5'(off)};
  endfunction

  function automatic logic [7:0] model_ch(input logic [31:0] w, input int nbytes,
                                          input logic [31:0] s, input bit act, input bit und);
    logic [31:0] m;
    logic [31:0] f;
    logic [7:0]  r;
    int off, len;
    off = int'(s[4:0]);
    len = int'(s[11:8]);
    if (!act || und || len == 0) return s[23:16];
    m = 32'h0;
    for (int b = 0; b < nbytes; b++) m[b*8 +: 8] = w[b*8 +: 8];
    f = 32'h0;
    for (int k = 0; k < len; k++)
      if (off + k < 32) f[k] = m[off + k];
    if (len >= 8) begin
      for (int k = 0; k < 8; k++) r[k] = f[len - 8 + k];
    end else begin
      for (int i = 0; i < 8; i++) r[7 - i] = f[len - 1 - (i % len)];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [31:0] w, input int nbytes,
                      input logic [31:0] rs, input logic [31:0] gs, input logic [31:0] bs,
                      input bit act, input bit und);
    @(negedge clk);
    pix_fmt     = {3'b000, 2'(nbytes - 1), 3'b000};
    red_sel     = rs;
    grn_sel     = gs;
    blu_sel     = bs;
    in_word     = w;
    in_active   = act;
    in_underrun = und;
    in_valid    = 1'b1;
    exp_q.push_back({model_ch(w, nbytes, rs, act, und),
                     model_ch(w, nbytes, gs, act, und),
                     model_ch(w, nbytes, bs, act, und)});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = in_word ^ 32'hA5C3_3C5A;
    end
  endtask

  // Monitor: compares each produced triple with the oldest expectation
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R9 actual=unexpected out_valid expected=no output");
      end else begin
        check(tag_q.pop_front(), {out_r, out_g, out_b}, exp_q.pop_front());
      end
    end
  end

  initial begin
    logic [31:0] r565, g565, b565, r888, g888, b888;
    logic [23:0] held;
    rst = 1'b1; in_valid = 1'b0; in_word = 32'h0; pix_fmt = 8'h0;
    red_sel = 32'h0; grn_sel = 32'h0; blu_sel = 32'h0;
    in_active = 1'b1; in_underrun = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset", {out_r, out_g, out_b}, 24'h0);
    check("R10 reset valid", {23'h0, out_valid}, 24'h0);
    rst = 1'b0;

    r565 = mk_sel(11, 5, 8'hFF); g565 = mk_sel(5, 6, 8'h00); b565 = mk_sel(0, 5, 8'h00);
    r888 = mk_sel(16, 8, 8'h11); g888 = mk_sel(8, 8, 8'h22); b888 = mk_sel(0, 8, 8'h33);

    // R2 short fields, 16-bit pixels
    send("R2 565 white", 32'h0000_FFFF, 2, r565, g565, b565, 1, 0);
    send("R2 565 mixed", 32'h0000_A5E1, 2, r565, g565, b565, 1, 0);
    send("R2 565 low", 32'h0000_0821, 2, r565, g565, b565, 1, 0);
    send("R2 len1", 32'h0000_0002, 1, mk_sel(1, 1, 8'h0), mk_sel(0, 1, 8'h0), mk_sel(2, 3, 8'h0), 1, 0);
    // R1 offsets, 32-bit pixels
    send("R1 888", 32'h00C0_FFEE, 4, r888, g888, b888, 1, 0);
    send("R1 888 b", 32'hFF12_3456, 4, r888, g888, b888, 1, 0);
    send("R1 odd off", 32'h0F0F_1234, 4, mk_sel(3, 8, 8'h0), mk_sel(13, 7, 8'h0), mk_sel(21, 4, 8'h0), 1, 0);
    // R3 long field
    send("R3 len12", 32'h0000_0ABC, 4, mk_sel(0, 12, 8'h0), mk_sel(4, 15, 8'h0), mk_sel(20, 9, 8'h0), 1, 0);
    // R7 byte masking
    send("R7 1byte", 32'hFFFF_FF5A, 1, r888, g888, b888, 1, 0);
    send("R7 3byte", 32'hFFAB_CDEF, 3, mk_sel(24, 8, 8'h0), g888, mk_sel(20, 8, 8'h0), 1, 0);
    // R8 past bit 31
    send("R8 top", 32'hF000_0000, 4, mk_sel(28, 8, 8'h0), mk_sel(31, 2, 8'h0), mk_sel(30, 4, 8'h0), 1, 0);
    // R4 zero length
    send("R4 len0", 32'hFFFF_FFFF, 4, mk_sel(0, 0, 8'h5A), mk_sel(8, 0, 8'hC3), b888, 1, 0);
    // R5 blanking
    send("R5 blank", 32'hFFFF_FFFF, 4, r888, g888, b888, 0, 0);
    // R6 underrun inside active area
    send("R6 underrun", 32'h1234_5678, 4, mk_sel(16, 8, 8'hFF), g888, b888, 1, 1);
    send("R6 und blank", 32'h1234_5678, 4, r888, g888, b888, 0, 1);
    // R9 back-to-back with gaps
    send("R9 b2b a", 32'h0000_F800, 2, r565, g565, b565, 1, 0);
    idle(2);
    send("R9 b2b b", 32'h0000_07E0, 2, r565, g565, b565, 1, 0);
    idle(2);
    // R10 hold while idle with changing inputs
    held = {out_r, out_g, out_b};
    red_sel = mk_sel(0, 8, 8'h77);
    idle(4);
    check("R10 hold", {out_r, out_g, out_b}, held);
    check("R9 queue drained", 24'(exp_q.size()), 24'h0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule